// File: doc/BRIEF.md
# Inter-Processor Message Target Matcher

This block decides whether one local interrupt unit is a recipient of an inter-processor message. It takes the unit's identity registers, the message's destination byte, the destination mode and a two-bit shorthand, plus a flag that says whether this unit sent the message. It returns a single match bit. Physical addressing compares the destination against the unit's own ID, and an all-ones destination reaches everyone. Logical addressing is interpreted in either flat form (a bitmask) or cluster form (cluster number plus member mask). The shorthands address the sender alone, all units, or all units except the sender, and they override the destination field.

The block also holds the two halves of the outgoing command word. A write to the high half keeps only the destination byte. A write to the low half stores the word with its delivery-pending bit forced clear and raises a one-cycle send strobe. Both halves are split into their fields for the delivery logic downstream. The match path has no registers. The command halves are registered and reset synchronously.

Top module: `ipi_target_match`

## Requirements
- R1: With shorthand 2'b00 and physical mode (`msg_logical`=0), `match` is 1 when `msg_dest` equals the local ID in `id_reg[31:24]` and 0 otherwise; bits 23:0 of `id_reg` have no effect.
- R2: With shorthand 2'b00 and physical mode, a destination of 8'hFF matches any local ID.
- R3: With shorthand 2'b00, logical mode and the format nibble `dfr_reg[31:28]` = 4'hF (flat), `match` is 1 exactly when `ldr_reg[31:24] & msg_dest` is nonzero.
- R4: With shorthand 2'b00, logical mode and format nibble 4'h0 (cluster), `match` is 1 exactly when the upper nibbles of `ldr_reg[31:24]` and `msg_dest` are equal and the AND of their lower nibbles is nonzero.
- R5: `fmt_err` is 1 whenever the format nibble is neither 4'hF nor 4'h0. In that case a logical-mode message with shorthand 2'b00 gives `match`=0, while physical mode still matches by R1/R2.
- R6: Shorthand 2'b01 (self) gives `match` = `is_sender`, whatever the destination.
- R7: Shorthand 2'b10 (all including self) always gives `match`=1.
- R8: Shorthand 2'b11 (all excluding self) gives `match` = !`is_sender`.
- R9: A write with `wr_hi` stores `wr_data[31:24]` into `cmd_hi_q[31:24]`, with bits 23:0 zero, visible the cycle after the write edge.
- R10: A write with `wr_lo` stores `wr_data` into `cmd_lo_q` with bit 12 (pending) cleared. `send_pulse` is 1 for exactly the one cycle after the write edge and is 0 when no low write happened on the previous edge.
- R11: The field outputs come from the stored words: vector = lo[7:0], delivery mode = lo[10:8], destination mode = lo[11], level = lo[14], trigger = lo[15], shorthand = lo[19:18], destination ID = hi[31:24].
- R12: Synchronous active-high `rst` clears both command halves and `send_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write strobe for the low command half; also starts a send |
| wr_hi | input | 1 | Write strobe for the high command half |
| wr_data | input | 32 | Write data for either half |
| id_reg | input | 32 | Local identity register; ID in bits 31:24 |
| ldr_reg | input | 32 | Logical identity register; logical ID in bits 31:24 |
| dfr_reg | input | 32 | Destination-format register; format nibble in bits 31:28 |
| msg_dest | input | 8 | Destination byte of the incoming message |
| msg_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| msg_shorthand | input | 2 | 00 none, 01 self, 10 all incl. self, 11 all excl. self |
| is_sender | input | 1 | This unit sent the message |
| match | output | 1 | This unit is a target |
| fmt_err | output | 1 | Format nibble is neither flat nor cluster |
| cmd_lo_q | output | 32 | Stored low command half |
| cmd_hi_q | output | 32 | Stored high command half |
| send_pulse | output | 1 | One-cycle strobe after a low-half write |
| f_vector | output | 8 | Vector field |
| f_dlv_mode | output | 3 | Delivery-mode field |
| f_dest_mode | output | 1 | Destination-mode field |
| f_level | output | 1 | Level field |
| f_trigger | output | 1 | Trigger field |
| f_shorthand | output | 2 | Shorthand field |
| f_dest_id | output | 8 | Destination ID from the high half |

## Verification
The bench aims at cases that are only one bit away from the correct answer. One is a cluster destination whose member mask overlaps the local one but names the wrong cluster; a design that ANDs all eight bits would accept it. Others are a flat mask with no common bit, an unknown format nibble in physical mode (which must still match), and shorthands with destination bytes that would match or miss on their own. A design that lets the destination leak through a shorthand would get these wrong. On the command side, the bench writes a low word with the pending bit set, writes the low and high halves in the same cycle, and places garbage in the low bits of the high write and the identity registers. These expose a pending bit that is not cleared, a send strobe that lasts too long, or unmasked bytes.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;

    localparam int REG_W = 32;
    localparam int ID_W  = 8;
    localparam int NIB_W = ID_W / 2;
    localparam int ID_LSB = REG_W - ID_W;

    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;
    localparam logic [ID_W-1:0] BCAST_ID = '1;

    localparam int PEND_BIT = 12;

    typedef enum logic [1:0] {
        SH_NONE    = 2'b00,
        SH_SELF    = 2'b01,
        SH_ALL_INC = 2'b10,
        SH_ALL_EXC = 2'b11
    } shorthand_e;

    typedef struct packed {
        logic [7:0]      vector;
        logic [2:0]      dlv_mode;
        logic            dest_mode;
        logic            level;
        logic            trigger;
        logic [1:0]      shorthand;
        logic [ID_W-1:0] dest_id;
    } cmd_fields_t;

    function automatic logic [ID_W-1:0] top_byte(input logic [REG_W-1:0] r);
        return r[REG_W-1 -: ID_W];
    endfunction

    function automatic logic flat_hit(input logic [ID_W-1:0] lid,
                                      input logic [ID_W-1:0] dst);
        return |(lid & dst);
    endfunction

    function automatic logic cluster_hit(input logic [ID_W-1:0] lid,
                                         input logic [ID_W-1:0] dst);
        return (lid[ID_W-1 -: NIB_W] == dst[ID_W-1 -: NIB_W]) &&
               (|(lid[NIB_W-1:0] & dst[NIB_W-1:0]));
    endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_match_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] lo_q,
    output logic [REG_W-1:0] hi_q,
    output logic             send_q
);

    localparam logic [REG_W-1:0] HI_KEEP = {{ID_W{1'b1}}, {ID_LSB{1'b0}}};
    localparam logic [REG_W-1:0] LO_KEEP = ~(REG_W'(1) << PEND_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            send_q <= 1'b0;
        end else begin
            send_q <= wr_lo;
            if (wr_lo) lo_q <= wr_data & LO_KEEP;
            if (wr_hi) hi_q <= wr_data & HI_KEEP;
        end
    end

    // R9: destination byte captured, rest zero
    a_r9_hi_mask: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (hi_q[REG_W-1 -: ID_W] == $past(wr_data[REG_W-1 -: ID_W]))
                  && (hi_q[ID_LSB-1:0] == '0));

    // R10: pending bit never survives a low write
    a_r10_pend_clear: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> !lo_q[PEND_BIT]);

    // R10: strobe follows a low write
    a_r10_send_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> send_q);

    // R10: no strobe without a low write
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !wr_lo |=> !send_q);

endmodule

// File: rtl/ipi_field_split.sv
module ipi_field_split
    import ipi_match_pkg::*;
(
    input  logic [REG_W-1:0] lo,
    input  logic [REG_W-1:0] hi,
    output cmd_fields_t      fields
);

    always_comb begin
        fields.vector    = lo[7:0];
        fields.dlv_mode  = lo[10:8];
        fields.dest_mode = lo[11];
        fields.level     = lo[14];
        fields.trigger   = lo[15];
        fields.shorthand = lo[19:18];
        fields.dest_id   = top_byte(hi);
    end

endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_match_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] id_reg,
    input  logic [REG_W-1:0] ldr_reg,
    input  logic [REG_W-1:0] dfr_reg,
    input  logic [ID_W-1:0]  dest,
    input  logic             logical,
    input  shorthand_e       sh,
    input  logic             is_sender,
    output logic             hit,
    output logic             err
);

    logic [ID_W-1:0] local_id;
    logic [ID_W-1:0] logical_id;
    logic [3:0]      fmt;
    logic            phys_hit;
    logic            logic_hit;
    logic            is_flat;
    logic            is_cluster;

    assign local_id   = top_byte(id_reg);
    assign logical_id = top_byte(ldr_reg);
    assign fmt        = dfr_reg[REG_W-1 -: 4];
    assign is_flat    = (fmt == FMT_FLAT);
    assign is_cluster = (fmt == FMT_CLUSTER);
    assign err        = !(is_flat || is_cluster);

    assign phys_hit = (dest == BCAST_ID) || (dest == local_id);

    always_comb begin
        logic_hit = 1'b0;
        if (is_flat)
            logic_hit = flat_hit(logical_id, dest);
        else if (is_cluster)
            logic_hit = cluster_hit(logical_id, dest);
    end

    always_comb begin
        unique case (sh)
            SH_NONE:    hit = logical ? logic_hit : phys_hit;
            SH_SELF:    hit = is_sender;
            SH_ALL_INC: hit = 1'b1;
            SH_ALL_EXC: hit = !is_sender;
            default:    hit = 1'b0;
        endcase
    end

    a_r7_all_inc: assert property (@(posedge clk) disable iff (rst)
        (sh == SH_ALL_INC) |-> hit);

    a_r6_self_only: assert property (@(posedge clk) disable iff (rst)
        (sh == SH_SELF) |-> (hit == is_sender));

    a_r8_all_exc: assert property (@(posedge clk) disable iff (rst)
        (sh == SH_ALL_EXC) |-> (hit != is_sender));

    a_r2_bcast: assert property (@(posedge clk) disable iff (rst)
        (sh == SH_NONE && !logical && dest == BCAST_ID) |-> hit);

    a_r5_bad_fmt: assert property (@(posedge clk) disable iff (rst)
        (sh == SH_NONE && logical && err) |-> !hit);

endmodule

// File: rtl/ipi_target_match.sv
module ipi_target_match
    import ipi_match_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wr_data,
    input  logic [31:0] id_reg,
    input  logic [31:0] ldr_reg,
    input  logic [31:0] dfr_reg,
    input  logic [7:0]  msg_dest,
    input  logic        msg_logical,
    input  logic [1:0]  msg_shorthand,
    input  logic        is_sender,
    output logic        match,
    output logic        fmt_err,
    output logic [31:0] cmd_lo_q,
    output logic [31:0] cmd_hi_q,
    output logic        send_pulse,
    output logic [7:0]  f_vector,
    output logic [2:0]  f_dlv_mode,
    output logic        f_dest_mode,
    output logic        f_level,
    output logic        f_trigger,
    output logic [1:0]  f_shorthand,
    output logic [7:0]  f_dest_id
);

    cmd_fields_t fields;
    shorthand_e  sh;

    assign sh = shorthand_e'(msg_shorthand);

    ipi_cmd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .lo_q    (cmd_lo_q),
        .hi_q    (cmd_hi_q),
        .send_q  (send_pulse)
    );

    ipi_field_split u_split (
        .lo     (cmd_lo_q),
        .hi     (cmd_hi_q),
        .fields (fields)
    );

    ipi_dest_match u_match (
        .clk       (clk),
        .rst       (rst),
        .id_reg    (id_reg),
        .ldr_reg   (ldr_reg),
        .dfr_reg   (dfr_reg),
        .dest      (msg_dest),
        .logical   (msg_logical),
        .sh        (sh),
        .is_sender (is_sender),
        .hit       (match),
        .err       (fmt_err)
    );

    assign f_vector    = fields.vector;
    assign f_dlv_mode  = fields.dlv_mode;
    assign f_dest_mode = fields.dest_mode;
    assign f_level     = fields.level;
    assign f_trigger   = fields.trigger;
    assign f_shorthand = fields.shorthand;
    assign f_dest_id   = fields.dest_id;

endmodule

// File: tb/ipi_target_match_tb.sv
module ipi_target_match_tb_top;

    localparam int CLK_P = 10;
    localparam int NVEC  = 16;

    typedef struct packed {
        logic [7:0] id;
        logic [7:0] ldr;
        logic [3:0] fmt;
        logic [7:0] dest;
        logic       lg;
        logic [1:0] sh;
        logic       snd;
        logic       em;
        logic       ee;
        logic [3:0] rq;
    } vec_t;

    // fields: id, ldr, fmt, dest, logical, shorthand, sender, exp match, exp err, req
    localparam vec_t TBL [NVEC] = '{
        '{8'h05, 8'h00, 4'hF, 8'h05, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd1},  // R1 hit
        '{8'h05, 8'h00, 4'hF, 8'h06, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 miss
        '{8'h05, 8'h00, 4'hF, 8'hFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
        '{8'h00, 8'h24, 4'hF, 8'h04, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 hit
        '{8'h00, 8'h24, 4'hF, 8'hDB, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 miss
        '{8'h00, 8'h31, 4'h0, 8'h33, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 hit
        '{8'h00, 8'h31, 4'h0, 8'h21, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 wrong cluster
        '{8'h00, 8'h31, 4'h0, 8'h32, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 no member
        '{8'h00, 8'hFF, 4'h8, 8'hFF, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 logical
        '{8'h05, 8'h00, 4'h8, 8'h05, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 physical
        '{8'h05, 8'h00, 4'hF, 8'h99, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 sender
        '{8'h05, 8'h00, 4'hF, 8'h05, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 other
        '{8'h05, 8'h00, 4'h3, 8'h00, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 other
        '{8'h05, 8'h00, 4'hF, 8'h00, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 sender
        '{8'h05, 8'h00, 4'hF, 8'h05, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 sender
        '{8'h05, 8'h00, 4'hF, 8'h00, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 4'd8}   // R8 other
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] id_reg = '0, ldr_reg = '0, dfr_reg = '0;
    logic [7:0]  msg_dest = '0;
    logic        msg_logical = 1'b0;
    logic [1:0]  msg_shorthand = '0;
    logic        is_sender = 1'b0;
    logic        match, fmt_err, send_pulse;
    logic [31:0] cmd_lo_q, cmd_hi_q;
    logic [7:0]  f_vector, f_dest_id;
    logic [2:0]  f_dlv_mode;
    logic        f_dest_mode, f_level, f_trigger;
    logic [1:0]  f_shorthand;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    ipi_target_match dut_i (
        .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .id_reg(id_reg), .ldr_reg(ldr_reg), .dfr_reg(dfr_reg),
        .msg_dest(msg_dest), .msg_logical(msg_logical),
        .msg_shorthand(msg_shorthand), .is_sender(is_sender),
        .match(match), .fmt_err(fmt_err), .cmd_lo_q(cmd_lo_q),
        .cmd_hi_q(cmd_hi_q), .send_pulse(send_pulse), .f_vector(f_vector),
        .f_dlv_mode(f_dlv_mode), .f_dest_mode(f_dest_mode), .f_level(f_level),
        .f_trigger(f_trigger), .f_shorthand(f_shorthand), .f_dest_id(f_dest_id)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        total++;
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(cmd_lo_q == 0, "R12 lo", cmd_lo_q, 0);
        chk(cmd_hi_q == 0, "R12 hi", cmd_hi_q, 0);
        chk(send_pulse == 0, "R12 send", {31'b0, send_pulse}, 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            id_reg        = {TBL[i].id, 24'h123456};
            ldr_reg       = {TBL[i].ldr, 24'hABCDEF};
            dfr_reg       = {TBL[i].fmt, 28'h0123456};
            msg_dest      = TBL[i].dest;
            msg_logical   = TBL[i].lg;
            msg_shorthand = TBL[i].sh;
            is_sender     = TBL[i].snd;
            #1;
            chk(match == TBL[i].em, $sformatf("R%0d match vec%0d", TBL[i].rq, i),
                {31'b0, match}, {31'b0, TBL[i].em});
            chk(fmt_err == TBL[i].ee, $sformatf("R%0d fmt_err vec%0d", TBL[i].rq, i),
                {31'b0, fmt_err}, {31'b0, TBL[i].ee});
        end
        @(negedge clk);
        msg_shorthand = 2'd0;
        msg_logical   = 1'b0;
        msg_dest      = 8'h00;
        dfr_reg       = 32'hF0000000;

        // R9: high write with garbage in low bits
        wr_hi = 1'b1; wr_data = 32'hA5FF_FFFF;
        @(negedge clk);
        wr_hi = 1'b0;
        chk(cmd_hi_q == 32'hA500_0000, "R9 hi mask", cmd_hi_q, 32'hA500_0000);
        chk(f_dest_id == 8'hA5, "R11 dest id", {24'b0, f_dest_id}, 32'hA5);
        chk(send_pulse == 0, "R10 no send on hi", {31'b0, send_pulse}, 0);

        // R10: low write with pending bit set
        wr_lo = 1'b1; wr_data = 32'h000C_D97E;
        @(negedge clk);
        wr_lo = 1'b0;
        chk(cmd_lo_q == 32'h000C_C97E, "R10 pend cleared", cmd_lo_q, 32'h000C_C97E);
        chk(send_pulse == 1, "R10 send high", {31'b0, send_pulse}, 1);
        // R11 fields
        chk(f_vector == 8'h7E, "R11 vector", {24'b0, f_vector}, 32'h7E);
        chk(f_dlv_mode == 3'd1, "R11 dlv", {29'b0, f_dlv_mode}, 1);
        chk(f_dest_mode == 1, "R11 dest mode", {31'b0, f_dest_mode}, 1);
        chk(f_level == 1, "R11 level", {31'b0, f_level}, 1);
        chk(f_trigger == 1, "R11 trigger", {31'b0, f_trigger}, 1);
        chk(f_shorthand == 2'd3, "R11 shorthand", {30'b0, f_shorthand}, 3);
        @(negedge clk);
        chk(send_pulse == 0, "R10 send one cycle", {31'b0, send_pulse}, 0);
        chk(cmd_lo_q == 32'h000C_C97E, "R10 lo held", cmd_lo_q, 32'h000C_C97E);

        // R10/R9: both halves in the same cycle
        wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 32'h3C04_0020;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
        chk(cmd_lo_q == 32'h3C04_0020, "R10 dual lo", cmd_lo_q, 32'h3C04_0020);
        chk(cmd_hi_q == 32'h3C00_0000, "R9 dual hi", cmd_hi_q, 32'h3C00_0000);
        chk(f_shorthand == 2'd1 && f_dest_mode == 0 && f_trigger == 0,
            "R11 dual fields", {30'b0, f_shorthand}, 1);
        chk(send_pulse == 1, "R10 dual send", {31'b0, send_pulse}, 1);

        // R12: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(cmd_lo_q == 0 && cmd_hi_q == 0, "R12 rerun regs", cmd_lo_q | cmd_hi_q, 0);
        chk(send_pulse == 0, "R12 rerun send", {31'b0, send_pulse}, 0);

        finish_run();
    end

endmodule